// File: doc/BRIEF.md
# Receive Sampling Delay Calibrator

This block sets up the receive sampling point for a memory-card host. It picks both the delay tap and the clock edge. It sweeps every delay tap on the rising sampling edge and then on the falling edge. For each tap it programs the tap and edge, requests one tuning transfer, and records whether the transfer came back clean. Each edge builds its own pass record. While the sweep runs, the block tracks the longest unbroken run of passing taps for each edge. When the sweep ends, a selector picks the edge and the tap phase inside that run.

Calibration runs on the command line first. When `with_data` is set and the command calibration found a usable window, the same sweep runs again on the data line. Data mode uses its own rule for choosing the edge. A single `done` pulse ends the sequence, and `pass` gives the overall status. An outside agent performs the tuning transfers. It sees a request, a block length, and a flag that tells command sweeps apart from data sweeps. A transfer that is never answered within the timeout budget counts as a failed tap.

Top module: `tune_seq`

## Requirements
- R1: For each line, the sweep visits tap 0 to 31 in rising order on the rising edge (edge code 0), then tap 0 to 31 on the falling edge (edge code 1). The command sweep drives `cmd_edge`/`cmd_tap` and the data sweep drives `dat_edge`/`dat_tap`. The edge and tap are in place for at least one cycle before `xfer_req` rises and stay unchanged while it is high.
- R2: A tap counts as passing only when `xfer_ack` arrives with `xfer_err` low. `xfer_req` falls in the cycle after the acknowledge.
- R3: The window for an edge is its longest run of consecutive passing taps, scanning upward from tap 0. Among runs of equal length, the lowest one wins. The chosen phase is length/3 (rounded down) when the run starts at tap 0. Otherwise it is start + length/2 (rounded down).
- R4: For the command line, the edge with the longer window is chosen. Equal lengths choose the rising edge.
- R5: For the data line, the rising edge is chosen whenever its window is 10 taps or longer. Otherwise the longer window wins, and equal lengths go to rising. One edge output, `dat_edge`, sets both read and write sampling.
- R6: If the chosen window has length zero (no passing tap), the sequence ends with `done` and `pass` low.
- R7: `bus_width` 2 means an 8-bit bus and requests 128-byte tuning blocks. `bus_width` 1 means a 4-bit bus and requests 64-byte blocks. Codes 0 (1-bit) and 3 end the sequence in the cycle after `start`, with `pass` low and no transfer.
- R8: A transfer with no acknowledge within `TMO_CYC` cycles of request counts as a failed tap. The request is withdrawn and the sweep moves on to the next tap.
- R9: With `with_data` low, only the command sweep runs (64 transfers). With it high, the data sweep (64 more transfers) runs only after the command sweep succeeds. `pass` goes high only if every sweep that ran found a window.
- R10: `done` is a one-cycle pulse. `start` has no effect while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration sequence (taken only when idle) |
| with_data | input | 1 | Also calibrate the data line after the command line |
| bus_width | input | 2 | 1 = 4-bit, 2 = 8-bit, 0/3 = rejected |
| xfer_req | output | 1 | Tuning transfer request, held until answer or timeout |
| xfer_data | output | 1 | High while the data line is being swept |
| xfer_len | output | 8 | Tuning block length in bytes |
| xfer_ack | input | 1 | Transfer finished this cycle |
| xfer_err | input | 1 | Finished transfer had an error (valid with ack) |
| cmd_edge | output | 1 | Command sampling edge (0 rising, 1 falling) |
| cmd_tap | output | 5 | Command sampling delay tap |
| dat_edge | output | 1 | Data read/write sampling edge |
| dat_tap | output | 5 | Data sampling delay tap |
| done | output | 1 | Sequence finished (one cycle) |
| pass | output | 1 | Status of the last finished sequence |

## Verification
The bench plays the card. It answers each request from pass maps chosen for each scenario, and it leaves chosen taps unanswered to force timeouts. It checks the tie cases: two equal runs on one edge, and equal window lengths on both edges in each mode. A design that got these wrong would pick the later run or the falling edge. It checks a data rising window of exactly 10 taps and one of 9 taps. A wrong threshold would take the falling edge in the first case or keep rising in the second. It also checks a run that starts at tap 0, where the one-third phase applies. Failing command calibration with data enabled must produce no data transfers. A rejected bus width and a `start` during a run are checked through the transfer count and the number of `done` pulses.

// File: rtl/tune_seq.sv
module tune_seq #(
  parameter int TAPS = 32,
  parameter int MIN_DATA_WIN = 10,
  parameter int TMO_CYC = 18_750_000,
  localparam int TW = $clog2(TAPS)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          with_data,
  input  logic [1:0]    bus_width,
  output logic          xfer_req,
  output logic          xfer_data,
  output logic [7:0]    xfer_len,
  input  logic          xfer_ack,
  input  logic          xfer_err,
  output logic          cmd_edge,
  output logic [TW-1:0] cmd_tap,
  output logic          dat_edge,
  output logic [TW-1:0] dat_tap,
  output logic          done,
  output logic          pass
);
  localparam int LW  = TW + 1;
  localparam int TMW = $clog2(TMO_CYC + 1);

  typedef enum logic [1:0] {IDLE, SET, REQ, PICK} st_t;
  st_t st;

  logic          in_data, wd_r, len8;
  logic          sw_edge;
  logic [TW-1:0] sw_tap, run_s;
  logic [LW-1:0] run_l;
  logic [TW-1:0] bs [2];
  logic [LW-1:0] bl [2];
  logic          cmd_fe, dat_fe;
  logic [TW-1:0] cmd_ft, dat_ft;
  logic [TMW-1:0] tmo;

  wire           sweeping = (st == SET) || (st == REQ);
  wire           hit      = xfer_ack && !xfer_err;
  wire           fin      = xfer_ack || (tmo == TMW'(TMO_CYC - 1));
  wire [LW-1:0]  nl       = run_l + LW'(1);
  wire [TW-1:0]  ns       = (run_l == '0) ? sw_tap : run_s;
  wire           pick_f   = (in_data && bl[0] >= LW'(MIN_DATA_WIN)) ? 1'b0 : (bl[1] > bl[0]);
  wire [LW-1:0]  cl       = pick_f ? bl[1] : bl[0];
  wire [TW-1:0]  cs       = pick_f ? bs[1] : bs[0];
  wire [TW-1:0]  ph       = (cs == '0) ? TW'(cl / LW'(3)) : TW'(cs + TW'(cl >> 1));

  assign xfer_req  = st == REQ;
  assign xfer_data = in_data;
  assign xfer_len  = len8 ? 8'd128 : 8'd64;
  assign cmd_edge  = (sweeping && !in_data) ? sw_edge : cmd_fe;
  assign cmd_tap   = (sweeping && !in_data) ? sw_tap  : cmd_ft;
  assign dat_edge  = (sweeping &&  in_data) ? sw_edge : dat_fe;
  assign dat_tap   = (sweeping &&  in_data) ? sw_tap  : dat_ft;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      in_data <= 1'b0; wd_r <= 1'b0; len8 <= 1'b0;
      sw_edge <= 1'b0; sw_tap <= '0; run_s <= '0; run_l <= '0;
      bs[0] <= '0; bs[1] <= '0; bl[0] <= '0; bl[1] <= '0;
      cmd_fe <= 1'b0; cmd_ft <= '0; dat_fe <= 1'b0; dat_ft <= '0;
      tmo <= '0; done <= 1'b0; pass <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          pass <= 1'b0;
          if (bus_width == 2'd1 || bus_width == 2'd2) begin
            len8 <= bus_width == 2'd2;
            wd_r <= with_data;
            in_data <= 1'b0;
            sw_edge <= 1'b0; sw_tap <= '0; run_l <= '0;
            bl[0] <= '0; bl[1] <= '0;
            st <= SET;
          end else begin
            done <= 1'b1;
          end
        end
        SET: begin
          tmo <= '0;
          st <= REQ;
        end
        REQ: begin
          if (fin) begin
            if (hit) begin
              run_l <= nl;
              run_s <= ns;
              if (nl > bl[sw_edge]) begin
                bl[sw_edge] <= nl;
                bs[sw_edge] <= ns;
              end
            end else begin
              run_l <= '0;
            end
            if (sw_tap == TW'(TAPS - 1)) begin
              if (!sw_edge) begin
                sw_edge <= 1'b1; sw_tap <= '0; run_l <= '0;
                st <= SET;
              end else begin
                st <= PICK;
              end
            end else begin
              sw_tap <= sw_tap + TW'(1);
              st <= SET;
            end
          end else begin
            tmo <= tmo + TMW'(1);
          end
        end
        PICK: begin
          if (cl == '0) begin
            done <= 1'b1; pass <= 1'b0;
            st <= IDLE;
          end else if (!in_data) begin
            cmd_fe <= pick_f; cmd_ft <= ph;
            if (wd_r) begin
              in_data <= 1'b1;
              sw_edge <= 1'b0; sw_tap <= '0; run_l <= '0;
              bl[0] <= '0; bl[1] <= '0;
              st <= SET;
            end else begin
              done <= 1'b1; pass <= 1'b1;
              st <= IDLE;
            end
          end else begin
            dat_fe <= pick_f; dat_ft <= ph;
            done <= 1'b1; pass <= 1'b1;
            st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tune_seq_chk.sv
module tune_seq_chk #(
  parameter int TAPS = 32,
  parameter int TMO_CYC = 18_750_000,
  localparam int TW = $clog2(TAPS)
)(
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_req,
  input logic          xfer_ack,
  input logic          xfer_data,
  input logic [7:0]    xfer_len,
  input logic          cmd_edge,
  input logic [TW-1:0] cmd_tap,
  input logic          dat_edge,
  input logic [TW-1:0] dat_tap,
  input logic          done
);
  logic [31:0] req_run;
  wire          live_edge = xfer_data ? dat_edge : cmd_edge;
  wire [TW-1:0] live_tap  = xfer_data ? dat_tap  : cmd_tap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) req_run <= '0;
    else        req_run <= xfer_req ? req_run + 32'd1 : 32'd0;

  p_tap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> ($stable(live_tap) && $stable(live_edge)));

  p_req_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_ack) |=> !xfer_req);

  p_len_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (xfer_len == 8'd64 || xfer_len == 8'd128));

  p_tmo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (req_run < 32'(TMO_CYC)));

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xfer_req);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind tune_seq tune_seq_chk #(.TAPS(TAPS), .TMO_CYC(TMO_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
  .xfer_data(xfer_data), .xfer_len(xfer_len), .cmd_edge(cmd_edge),
  .cmd_tap(cmd_tap), .dat_edge(dat_edge), .dat_tap(dat_tap), .done(done)
);

// File: tb/tb_tune_seq.sv
`timescale 1ns/1ps
module tb_tune_seq;
  localparam int TMO = 20;

  logic clk = 0, rst_n = 0;
  logic start = 0, with_data = 0;
  logic [1:0] bus_width = 2'd1;
  logic xfer_req, xfer_data, xfer_ack = 0, xfer_err = 0;
  logic [7:0] xfer_len;
  logic cmd_edge, dat_edge, done, pass;
  logic [4:0] cmd_tap, dat_tap;

  tune_seq #(.TMO_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .with_data(with_data),
    .bus_width(bus_width), .xfer_req(xfer_req), .xfer_data(xfer_data),
    .xfer_len(xfer_len), .xfer_ack(xfer_ack), .xfer_err(xfer_err),
    .cmd_edge(cmd_edge), .cmd_tap(cmd_tap), .dat_edge(dat_edge),
    .dat_tap(dat_tap), .done(done), .pass(pass));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int xfer_idx = 0, ordbad = 0, lenbad = 0, done_cnt = 0;
  int exp_len = 64;
  logic [31:0] m_cr, m_cf, m_dr, m_df, m_sil;
  bit pend = 0, cur_sil = 0, cur_bit = 0;
  int wait_n = 0;
  longint cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // card model: answers each request after a short latency
  always @(negedge clk) begin
    xfer_ack = 0;
    xfer_err = 0;
    if (done) done_cnt++;
    if (!xfer_req) pend = 0;
    else if (!pend) begin
      logic e; logic [4:0] t; logic [31:0] m;
      pend = 1;
      wait_n = 2;
      e = xfer_data ? dat_edge : cmd_edge;
      t = xfer_data ? dat_tap : cmd_tap;
      if (xfer_data != (xfer_idx >= 64) || e != xfer_idx[5] || t != xfer_idx[4:0]) ordbad++;
      if (xfer_len != 8'(exp_len)) lenbad++;
      xfer_idx++;
      m = xfer_data ? (e ? m_df : m_dr) : (e ? m_cf : m_cr);
      cur_bit = m[t];
      cur_sil = !xfer_data && !e && m_sil[t];
    end else if (!cur_sil) begin
      if (wait_n == 0) begin
        xfer_ack = 1;
        xfer_err = !cur_bit;
      end else wait_n--;
    end
  end

  task automatic chk(input bit ok, input string tag, input string nm, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  function automatic void best_win(input logic [31:0] m, output int len, output int st);
    int cur = 0;
    len = 0; st = 0;
    for (int i = 0; i < 32; i++) begin
      if (m[i]) begin
        cur++;
        if (cur > len) begin len = cur; st = i - cur + 1; end
      end else cur = 0;
    end
  endfunction

  function automatic int phase_of(input int len, input int st);
    return (st == 0) ? len / 3 : st + len / 2;
  endfunction

  task automatic choose(input logic [31:0] rm, input logic [31:0] fm, input bit data,
                        output int edge_o, output int tap_o, output bit ok);
    int lr, sr, lf, sf;
    best_win(rm, lr, sr);
    best_win(fm, lf, sf);
    if (data && lr >= 10) edge_o = 0;
    else edge_o = (lf > lr) ? 1 : 0;
    ok = (edge_o == 1) ? (lf > 0) : (lr > 0);
    tap_o = (edge_o == 1) ? phase_of(lf, sf) : phase_of(lr, sr);
  endtask

  task automatic run(input string nm, input string tag, input logic [1:0] bw, input bit wd,
                     input logic [31:0] cr, input logic [31:0] cf, input logic [31:0] dr,
                     input logic [31:0] df, input logic [31:0] sil, input bit busy_start);
    int ce, ct, de, dt, n, exp_cnt, d0;
    bit cok, dok, exp_pass, legal;
    m_cr = cr; m_cf = cf; m_dr = dr; m_df = df; m_sil = sil;
    xfer_idx = 0; ordbad = 0; lenbad = 0;
    legal = (bw == 2'd1 || bw == 2'd2);
    exp_len = (bw == 2'd2) ? 128 : 64;
    choose(cr & ~sil, cf, 1'b0, ce, ct, cok);
    choose(dr, df, 1'b1, de, dt, dok);
    exp_pass = legal && cok && (!wd || dok);
    exp_cnt = !legal ? 0 : (cok && wd) ? 128 : 64;
    d0 = done_cnt;
    bus_width = bw; with_data = wd;
    start = 1;
    @(negedge clk);
    start = 0;
    if (busy_start) begin
      repeat (30) @(negedge clk);
      bus_width = 2'd0; start = 1;
      @(negedge clk);
      start = 0; bus_width = bw;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done === 1'b1, "R10", {nm, " done seen"}, int'(done), 1);
    chk(pass === exp_pass, legal ? "R6" : "R7", {nm, " pass"}, int'(pass), int'(exp_pass));
    if (legal && cok) begin
      chk(cmd_edge == ce[0], tag, {nm, " cmd edge"}, int'(cmd_edge), ce);
      chk(int'(cmd_tap) == ct, "R3", {nm, " cmd tap"}, int'(cmd_tap), ct);
    end
    if (legal && cok && wd && dok) begin
      chk(dat_edge == de[0], "R5", {nm, " data edge"}, int'(dat_edge), de);
      chk(int'(dat_tap) == dt, "R5", {nm, " data tap"}, int'(dat_tap), dt);
    end
    chk(xfer_idx == exp_cnt, "R9", {nm, " transfer count"}, xfer_idx, exp_cnt);
    chk(ordbad == 0, "R1", {nm, " sweep order"}, ordbad, 0);
    chk(lenbad == 0, "R7", {nm, " block length"}, lenbad, 0);
    @(negedge clk);
    chk(done === 1'b0 && done_cnt == d0 + 1, "R10", {nm, " single done"}, done_cnt - d0, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 1'b0, "R10", "reset done", int'(done), 0);
    chk(xfer_req === 1'b0, "R2", "reset req", int'(xfer_req), 0);
    chk(cmd_tap == 5'd0 && dat_tap == 5'd0, "R1", "reset taps", int'(cmd_tap), 0);
    rst_n = 1;
    @(negedge clk);
    run("all pass tie", "R4", 2'd1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0);
    run("falling longer", "R4", 2'd2, 0, 32'h0000_00F0, 32'h00FF_0000, 0, 0, 0, 0);
    run("falling only", "R4", 2'd1, 0, 32'h0, 32'h8000_0000, 0, 0, 0, 0);
    run("cmd none", "R6", 2'd1, 0, 32'h0, 32'h0, 0, 0, 0, 0);
    run("data rise 10", "R5", 2'd2, 1, 32'hFFFF_FFFF, 32'h0, 32'h0000_1FF8, 32'h000F_FFFF, 0, 0);
    run("data rise 9", "R5", 2'd1, 1, 32'h0000_FF00, 32'h0, 32'h0000_01FF, 32'h0000_FFF0, 0, 0);
    run("data tie", "R5", 2'd1, 1, 32'h0000_FF00, 32'h0, 32'h0000_3FE0, 32'h1FF0_0000, 0, 0);
    run("data none", "R6", 2'd1, 1, 32'h0000_FFFF, 32'h0, 32'h0, 32'h0, 0, 0);
    run("cmd fail skips data", "R9", 2'd2, 1, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    run("one bit bus", "R7", 2'd0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0);
    run("bad width code", "R7", 2'd3, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0);
    run("timeouts", "R8", 2'd1, 0, 32'hFFFF_FFFF, 32'h0, 0, 0, 32'h0000_0060, 0);
    run("equal runs", "R3", 2'd1, 0, 32'h0000_3C3C, 32'h0, 0, 0, 0, 0);
    run("busy start", "R10", 2'd1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    total++; bad++;
    $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule